// File: doc/BRIEF.md
# Two-Wire Bus Recovery Sequencer

This block sits on the master side of a two-wire serial bus and frees the bus after an interruption. A protocol break, a power loss or a system reset can leave a slave partway through a transfer, holding the data line low while it waits for more clocks. When the block receives a recovery request, it clocks the bus one pulse at a time and looks at the data line near the end of each clock-high phase. As soon as that line reads high, the block generates a start condition and then a stop condition, which returns the bus to idle, and reports success. If the line is still low after the last permitted pulse, the block releases both lines and reports failure.

Both lines are open-drain and are pulled up outside the block, so each output is a "drive low" enable and never drives the line high. Each clock phase lasts a parameterised number of system clocks, `HALF_CLKS`. The data-line input passes through a synchroniser whose depth is a parameter; a depth of zero selects a direct path. The pulse limit is `MAX_PULSES`, which defaults to nine.

Top module: `busrec_seq`

## Requirements
- R1: After reset, and whenever no sequence is running, `scl_drive_low` and `sda_drive_low` are both 0 and `done` and `fail` are both 0.
- R2: A request in the idle state starts the clocking phase on the next clock edge. SCL is held low for `HALF_CLKS` clocks and then released for `HALF_CLKS` clocks, and this repeats for each pulse. `sda_drive_low` stays 0 during the whole clocking phase.
- R3: The block samples the synchronised data line on the last clock of each SCL-high phase. The number of SCL pulses equals the index of the first high phase in which the line reads 1, and it never exceeds `MAX_PULSES`.
- R4: When the line reads 1, SCL stays released and `sda_drive_low` rises, which forms a start condition. This state holds for `HALF_CLKS` clocks.
- R5: After the start condition, the block drives SCL low for `HALF_CLKS` clocks and then releases SCL with SDA still low for `HALF_CLKS` clocks. It then releases SDA while SCL is high, which forms a stop condition, and in the same cycle it raises `done` for exactly one clock. When the request is taken on edge 0, `done` is first high after edge `HALF_CLKS*(2P+3)`, where P is the pulse count.
- R6: If the line is still 0 at the end of high phase number `MAX_PULSES`, both drives are 0, `fail` is high for exactly one clock after edge `2*MAX_PULSES*HALF_CLKS`, no start condition is produced and `done` stays 0.
- R7: A request that arrives while a sequence is running is ignored. Pulse count, timing and outcome are the same as without it.
- R8: Asserting reset (`rst_n` = 0) in the middle of a sequence releases both lines and clears `done` and `fail` at once. The next request then runs a complete new sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| recover_req | input | 1 | Starts a recovery sequence when the block is idle |
| sda_in | input | 1 | Sensed level of the data line |
| scl_drive_low | output | 1 | 1 pulls the clock line low, 0 releases it |
| sda_drive_low | output | 1 | 1 pulls the data line low, 0 releases it |
| done | output | 1 | One-clock pulse when the bus has been recovered |
| fail | output | 1 | One-clock pulse when the data line stayed low after the last pulse |

## Verification
The bench sweeps a model slave that releases the data line after 0 to 10 pulses. This covers a release on the very first pulse, a release on the last permitted pulse and a line that never comes free. A design that counts pulses wrongly gives up one pulse early or clocks a tenth time. Every phase width and the completion edge are compared against arithmetic expectations, so a timer that is off by one, or a sample taken before the synchroniser has settled, shows up as a wrong edge count or a wrong pulse count. The bench checks that the start condition and the stop condition both occur while SCL is high, which catches a design that reorders its drives. It injects extra requests mid-sequence and asserts reset mid-sequence, which catches a design that restarts itself or leaves a line held low.

// File: rtl/busrec_pkg.sv
package busrec_pkg;

   typedef enum logic [2:0] {
      ST_IDLE       = 3'd0,
      ST_CLK_LOW    = 3'd1,
      ST_CLK_HIGH   = 3'd2,
      ST_START      = 3'd3,
      ST_STOP_LOW   = 3'd4,
      ST_STOP_SETUP = 3'd5
   } rec_state_t;

   function automatic logic pulls_scl(input rec_state_t s);
      return (s == ST_CLK_LOW) || (s == ST_STOP_LOW);
   endfunction

   function automatic logic pulls_sda(input rec_state_t s);
      return (s == ST_START) || (s == ST_STOP_LOW) || (s == ST_STOP_SETUP);
   endfunction

endpackage

// File: rtl/busrec_sync.sv
module busrec_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   generate
      if (STAGES == 0) begin : g_direct
         assign q = d;
      end else begin : g_chain
         logic [STAGES-1:0] chain_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               chain_q <= '1;
            end else begin
               chain_q[0] <= d;
               for (int i = 1; i < STAGES; i++) begin
                  chain_q[i] <= chain_q[i-1];
               end
            end
         end
         assign q = chain_q[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/busrec_phase_timer.sv
module busrec_phase_timer #(
   parameter int HALF_CLKS = 250
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic tick
);

   localparam int TW = (HALF_CLKS > 1) ? $clog2(HALF_CLKS) : 1;
   localparam logic [TW-1:0] LAST = TW'(HALF_CLKS - 1);

   logic [TW-1:0] cnt_q;

   assign tick = run && (cnt_q == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (!run || tick) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + TW'(1);
      end
   end

   assert_timer_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= LAST);

   assert_timer_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> (cnt_q == '0));

endmodule

// File: rtl/busrec_pulse_ctr.sv
module busrec_pulse_ctr #(
   parameter int MAX_PULSES = 9
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic inc,
   output logic at_limit
);

   localparam int CW = $clog2(MAX_PULSES + 1);
   localparam logic [CW-1:0] LIMIT = CW'(MAX_PULSES);

   logic [CW-1:0] cnt_q;

   assign at_limit = (cnt_q == LIMIT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clear) begin
         cnt_q <= '0;
      end else if (inc) begin
         cnt_q <= cnt_q + CW'(1);
      end
   end

   assert_pulse_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= LIMIT);

   assert_no_inc_at_limit_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (at_limit && !clear) |-> !inc);

endmodule

// File: rtl/busrec_seq.sv
module busrec_seq
   import busrec_pkg::*;
#(
   parameter int HALF_CLKS   = 250,
   parameter int MAX_PULSES  = 9,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic recover_req,
   input  logic sda_in,
   output logic scl_drive_low,
   output logic sda_drive_low,
   output logic done,
   output logic fail
);

   generate
      if (HALF_CLKS < SYNC_STAGES + 1) begin : g_bad_half
         $error("HALF_CLKS must exceed SYNC_STAGES so the sample sees a settled line");
      end
      if (MAX_PULSES < 1) begin : g_bad_max
         $error("MAX_PULSES must be at least 1");
      end
      if (SYNC_STAGES < 0) begin : g_bad_sync
         $error("SYNC_STAGES must not be negative");
      end
   endgenerate

   rec_state_t st_q, st_d;
   logic       tick;
   logic       sda_s;
   logic       at_limit;
   logic       cnt_clear, cnt_inc;
   logic       done_d, fail_d;

   busrec_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (sda_in),
      .q     (sda_s)
   );

   busrec_phase_timer #(.HALF_CLKS(HALF_CLKS)) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (st_q != ST_IDLE),
      .tick  (tick)
   );

   busrec_pulse_ctr #(.MAX_PULSES(MAX_PULSES)) u_pulses (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear    (cnt_clear),
      .inc      (cnt_inc),
      .at_limit (at_limit)
   );

   always_comb begin
      st_d      = st_q;
      cnt_clear = 1'b0;
      cnt_inc   = 1'b0;
      done_d    = 1'b0;
      fail_d    = 1'b0;
      unique case (st_q)
         ST_IDLE: begin
            if (recover_req) begin
               st_d      = ST_CLK_LOW;
               cnt_clear = 1'b1;
            end
         end
         ST_CLK_LOW: begin
            if (tick) begin
               st_d    = ST_CLK_HIGH;
               cnt_inc = 1'b1;
            end
         end
         ST_CLK_HIGH: begin
            if (tick) begin
               if (sda_s) begin
                  st_d = ST_START;
               end else if (at_limit) begin
                  st_d   = ST_IDLE;
                  fail_d = 1'b1;
               end else begin
                  st_d = ST_CLK_LOW;
               end
            end
         end
         ST_START: begin
            if (tick) st_d = ST_STOP_LOW;
         end
         ST_STOP_LOW: begin
            if (tick) st_d = ST_STOP_SETUP;
         end
         ST_STOP_SETUP: begin
            if (tick) begin
               st_d   = ST_IDLE;
               done_d = 1'b1;
            end
         end
         default: st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q <= ST_IDLE;
         done <= 1'b0;
         fail <= 1'b0;
      end else begin
         st_q <= st_d;
         done <= done_d;
         fail <= fail_d;
      end
   end

   assign scl_drive_low = pulls_scl(st_q);
   assign sda_drive_low = pulls_sda(st_q);

   assert_phase_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q != ST_IDLE && !tick) |=> (st_q == $past(st_q)));

   assert_start_scl_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sda_drive_low) |-> !scl_drive_low);

   assert_stop_with_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sda_drive_low) |-> (!scl_drive_low && done));

   assert_done_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_fail_released_R6: assert property (@(posedge clk) disable iff (!rst_n)
      fail |-> (!scl_drive_low && !sda_drive_low && !done));

   assert_fail_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
      fail |=> !fail);

   assert_busy_ignores_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_START && recover_req) |=> (st_q != ST_CLK_LOW));

endmodule

// File: tb/busrec_seq_tb.sv
module busrec_seq_tb;

   localparam int HALF = 4;
   localparam int MAXP = 9;
   localparam int SYNC = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req = 1'b0;
   logic slave_hold = 1'b1;
   logic scl_low, sda_low, done, fail;
   logic sda_in;
   logic prev_scl = 1'b0;

   int tests = 0;
   int fails = 0;
   int falls = 0;
   int slave_n = 0;

   always #10 clk = ~clk;

   assign sda_in = !(sda_low || slave_hold);

   busrec_seq #(
      .HALF_CLKS   (HALF),
      .MAX_PULSES  (MAXP),
      .SYNC_STAGES (SYNC)
   ) u_dut (
      .clk           (clk),
      .rst_n         (rst_n),
      .recover_req   (req),
      .sda_in        (sda_in),
      .scl_drive_low (scl_low),
      .sda_drive_low (sda_low),
      .done          (done),
      .fail          (fail)
   );

   // model slave: holds SDA low until it has seen slave_n complete pulses
   always @(negedge clk) begin
      if (scl_low && !prev_scl) falls = falls + 1;
      prev_scl   = scl_low;
      slave_hold = (falls < slave_n + 1);
   end

   task automatic check(input bit ok, input string tag, input string what,
                        input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   task automatic summary();
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
   endtask

   task automatic run_case(input int n, input int inject);
      int   edges = 0, pulses = 0, sda_rises = 0, bad_width = 0;
      int   seg = 0, changes = 0, end_edge = -1;
      bit   ok_start = 1, ok_stop = 1, sda_seen = 0, got_done = 0, got_fail = 0;
      logic pscl, psda;
      int   exp_p = (n + 1 <= MAXP) ? n + 1 : MAXP;
      bit   exp_ok = (n + 1 <= MAXP);
      int   exp_end = exp_ok ? HALF * (2 * exp_p + 3) + 1 : 2 * MAXP * HALF + 1;
      @(negedge clk); #1;
      slave_n = n; falls = 0; slave_hold = 1'b1;
      req = 1'b1; pscl = scl_low; psda = sda_low;
      @(negedge clk); #1;
      req = 1'b0;
      while (end_edge < 0 && edges < 400) begin
         edges++;
         req = (inject == edges);
         if (scl_low != pscl) begin
            changes++;
            if (changes > 1 && !sda_seen && seg != HALF) bad_width++;
            seg = 1;
            if (!scl_low && !sda_seen) pulses++;
         end else begin
            seg++;
         end
         if (sda_low && !psda) begin
            sda_rises++; sda_seen = 1;
            if (scl_low) ok_start = 0;
         end
         if (!sda_low && psda) begin
            if (scl_low || !done) ok_stop = 0;
         end
         if (done || fail) begin
            end_edge = edges; got_done = done; got_fail = fail;
         end
         pscl = scl_low; psda = sda_low;
         @(negedge clk); #1;
      end
      req = 1'b0;
      check(pulses == exp_p, "R3", $sformatf("pulse count n=%0d", n), pulses, exp_p);
      check(bad_width == 0, "R2", $sformatf("phase widths n=%0d", n), bad_width, 0);
      check(sda_rises == (exp_ok ? 1 : 0), "R2", $sformatf("sda quiet n=%0d", n),
            sda_rises, exp_ok ? 1 : 0);
      check(end_edge == exp_end, exp_ok ? "R5" : "R6",
            $sformatf("completion edge n=%0d", n), end_edge, exp_end);
      if (exp_ok) begin
         check(got_done && !got_fail, "R5", $sformatf("done outcome n=%0d", n),
               int'(got_done), 1);
         check(ok_start, "R4", $sformatf("start with scl high n=%0d", n), int'(ok_start), 1);
         check(ok_stop, "R5", $sformatf("stop with scl high and done n=%0d", n),
               int'(ok_stop), 1);
      end else begin
         check(got_fail && !got_done, "R6", $sformatf("fail outcome n=%0d", n),
               int'(got_fail), 1);
      end
      check(!done && !fail && !scl_low && !sda_low, "R1",
            $sformatf("idle after end n=%0d", n), int'({done, fail, scl_low, sda_low}), 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      #1;
      check(!scl_low && !sda_low && !done && !fail, "R1", "outputs in reset",
            int'({done, fail, scl_low, sda_low}), 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      #1;
      check(!scl_low && !sda_low && !done && !fail, "R1", "outputs idle after reset",
            int'({done, fail, scl_low, sda_low}), 0);

      // sweep the slave release point through and past the pulse limit (R2..R6)
      for (int n = 0; n <= MAXP + 1; n++) run_case(n, 0);

      // R7: extra requests during clocking and during the stop sequence
      run_case(3, HALF * 3);
      run_case(2, HALF * 7 + 2);
      run_case(MAXP, HALF * 5);

      // R8: reset in the middle of a sequence
      @(negedge clk); #1;
      slave_n = MAXP; falls = 0; req = 1'b1;
      @(negedge clk); #1;
      req = 1'b0;
      repeat (HALF + 2) @(negedge clk);
      #1;
      rst_n = 1'b0;
      #2;
      check(!scl_low && !sda_low && !done && !fail, "R8", "lines released on reset",
            int'({done, fail, scl_low, sda_low}), 0);
      @(negedge clk); #1;
      rst_n = 1'b1;
      run_case(1, 0);

      summary();
      $finish;
   end

endmodule